// File: doc/BRIEF.md
# Peripheral Interrupt Level Router

This block gathers level-sensitive interrupt requests from up to 32 on-chip peripherals and routes each one to one of seven core priority levels, numbered 7 through 13. Software chooses the level of every source by writing a 4-bit routing field. It enables or disables sources through a mask register. The block drives one request line per core level, and that line is high while any enabled, pending source routed to the level is present.

When the core takes an interrupt at a given level, it issues a query carrying that level. One clock later the block answers with the peripheral that should be serviced: the lowest-numbered source routed to the level whose request is both pending and enabled. If no such source exists, the answer is flagged as spurious instead. A saturating counter keeps the number of spurious answers. A small register port gives access to the status, mask, routing fields and counter.

Top module: `pirq_level_router`

## Requirements
- R1: The status register (address 0, read-only) holds `periph_req` as sampled at the previous rising clock edge. Writes to address 0 have no effect.
- R2: Mask bit k (address 1, read/write) enables source k when set. The effective pending set is status AND mask. With the mask at zero, no level request line is raised.
- R3: Source n is routed by the 4-bit field at bits [4*(n mod 8)+3 : 4*(n mod 8)] of routing register n/8, at addresses 2 to 5. Field value v selects core level 7+v, driven on `lvl_irq[v]`.
- R4: `lvl_irq[v]` is the OR of the effective pending bits of all sources whose field equals v. It follows a change of status, mask or routing register with no added clock.
- R5: A field value from 7 to 15 routes its source to no level. That source raises no request line and is never selected.
- R6: A query (`qry_valid` high, `qry_lvl` = v, 0 to 6 meaning level 7+v) yields `rsp_valid` on the next clock. `rsp_src` then names the lowest-numbered source routed to level v whose effective pending bit was set at the query edge.
- R7: If no source qualifies, or `qry_lvl` is above 6, the response has `rsp_spurious` = 1 and `rsp_src` = 0.
- R8: The spurious counter (address 6, read-only, CNT_W bits) increments once per spurious response. It saturates at 2^CNT_W-1 and does not change without a query.
- R9: After reset the mask is zero, every routing field is zero (all sources at level 7), the counter is zero, and `lvl_irq`, `rsp_valid` and `bus_rdata` are zero.
- R10: A read (`bus_rd` high) returns the addressed register on `bus_rdata` one clock later. Unused addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_req | input | NUM_SRC | Raw peripheral request levels |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the clock after `bus_rd` |
| lvl_irq | output | NUM_LVL | Request line per core level, bit v is level 7+v |
| qry_valid | input | 1 | Service query strobe |
| qry_lvl | input | 4 | Queried level offset (0 = level 7) |
| rsp_valid | output | 1 | Query response valid |
| rsp_spurious | output | 1 | No qualifying source for the query |
| rsp_src | output | SRC_W | Selected source index |

## Verification
The results fall due at different times. A request change reaches the status register at the next edge, and `lvl_irq` reflects it immediately after that edge. Register writes show on `lvl_irq` right after their own edge. Query responses and read data appear one edge after the strobe. The bench drives every input on the falling edge and samples each result on the first falling edge after the edge that makes it due. The expected value is computed from a bench model of status, mask, routing and counter as they stood at the edge that launched the operation.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int FLD_W     = 4;
  localparam int A_STATUS  = 0;
  localparam int A_MASK    = 1;
  localparam int A_ROUTE0  = 2;
endpackage

// File: rtl/pirq_regs.sv
module pirq_regs
  import pirq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3,
  parameter int CNT_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SRC-1:0]       req_i,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  input  logic [CNT_W-1:0]         spur_cnt_i,
  output logic [NUM_SRC-1:0]       stat_o,
  output logic [NUM_SRC-1:0]       mask_o,
  output logic [NUM_SRC*FLD_W-1:0] fld_o
);
  localparam int FPR     = DATA_W / FLD_W;
  localparam int NUM_RTE = (NUM_SRC + FPR - 1) / FPR;
  localparam int A_SPUR  = A_ROUTE0 + NUM_RTE;

  logic [NUM_SRC-1:0] stat_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [DATA_W-1:0]  rte_q [NUM_RTE];
  logic [DATA_W-1:0]  rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '0;
      for (int i = 0; i < NUM_RTE; i++) rte_q[i] <= '0;
      rdata  <= '0;
    end else begin
      stat_q <= req_i;
      if (wr_en) begin
        if (addr == ADDR_W'(A_MASK)) mask_q <= wdata[NUM_SRC-1:0];
        for (int i = 0; i < NUM_RTE; i++)
          if (addr == ADDR_W'(A_ROUTE0 + i)) rte_q[i] <= wdata;
      end
      if (rd_en) rdata <= rd_mux;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(A_STATUS)) rd_mux = DATA_W'(stat_q);
    if (addr == ADDR_W'(A_MASK))   rd_mux = DATA_W'(mask_q);
    for (int i = 0; i < NUM_RTE; i++)
      if (addr == ADDR_W'(A_ROUTE0 + i)) rd_mux = rte_q[i];
    if (addr == ADDR_W'(A_SPUR))   rd_mux = DATA_W'(spur_cnt_i);
  end

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_fld
    assign fld_o[n*FLD_W +: FLD_W] = rte_q[n / FPR][(n % FPR)*FLD_W +: FLD_W];
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;

  // R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == ADDR_W'(A_MASK)) |=> $stable(mask_q));

endmodule

// File: rtl/pirq_level_decode.sv
module pirq_level_decode
  import pirq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_LVL = 7
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SRC-1:0]         stat_i,
  input  logic [NUM_SRC-1:0]         mask_i,
  input  logic [NUM_SRC*FLD_W-1:0]   fld_i,
  output logic [NUM_LVL*NUM_SRC-1:0] hits_o,
  output logic [NUM_LVL-1:0]         lvl_irq_o
);
  logic [NUM_SRC-1:0] eff;
  assign eff = stat_i & mask_i;

  for (genvar j = 0; j < NUM_LVL; j++) begin : g_lvl
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      assign hits_o[j*NUM_SRC + n] =
        eff[n] && (fld_i[n*FLD_W +: FLD_W] == FLD_W'(j));
    end
    assign lvl_irq_o[j] = |hits_o[j*NUM_SRC +: NUM_SRC];
  end

  // R2
  mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_i == '0) |-> (lvl_irq_o == '0));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_i == '0) |-> (lvl_irq_o == '0));

endmodule

// File: rtl/pirq_select.sv
module pirq_select
  import pirq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_LVL = 7,
  parameter int CNT_W   = 8,
  parameter int SRC_W   = $clog2(NUM_SRC)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       qry_valid,
  input  logic [FLD_W-1:0]           qry_lvl,
  input  logic [NUM_LVL*NUM_SRC-1:0] hits_i,
  output logic                       rsp_valid,
  output logic                       rsp_spurious,
  output logic [SRC_W-1:0]           rsp_src,
  output logic [CNT_W-1:0]           spur_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_SRC-1:0] row;
  logic               found;
  logic [SRC_W-1:0]   idx;

  always_comb begin
    row = '0;
    for (int j = 0; j < NUM_LVL; j++)
      if (qry_lvl == FLD_W'(j)) row = hits_i[j*NUM_SRC +: NUM_SRC];
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int n = NUM_SRC - 1; n >= 0; n--) begin
      if (row[n]) begin
        found = 1'b1;
        idx   = SRC_W'(n);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_spurious <= 1'b0;
      rsp_src      <= '0;
      spur_cnt     <= '0;
    end else begin
      rsp_valid    <= qry_valid;
      rsp_spurious <= qry_valid && !found;
      rsp_src      <= (qry_valid && found) ? idx : '0;
      if (qry_valid && !found && spur_cnt != CNT_MAX)
        spur_cnt <= spur_cnt + 1'b1;
    end
  end

  // R6
  rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    qry_valid |=> rsp_valid);

  // R7
  spur_src_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_spurious) |-> (rsp_src == '0));

  // R8
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (spur_cnt == CNT_MAX) |=> (spur_cnt == CNT_MAX));

  // R8
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !qry_valid |=> $stable(spur_cnt));

endmodule

// File: rtl/pirq_level_router.sv
module pirq_level_router
  import pirq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_LVL = 7,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3,
  parameter int CNT_W   = 8,
  parameter int SRC_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] periph_req,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [NUM_LVL-1:0] lvl_irq,
  input  logic               qry_valid,
  input  logic [3:0]         qry_lvl,
  output logic               rsp_valid,
  output logic               rsp_spurious,
  output logic [SRC_W-1:0]   rsp_src
);
  logic [NUM_SRC-1:0]         stat;
  logic [NUM_SRC-1:0]         mask;
  logic [NUM_SRC*FLD_W-1:0]   fld;
  logic [NUM_LVL*NUM_SRC-1:0] hits;
  logic [CNT_W-1:0]           spur_cnt;

  pirq_regs #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst(rst), .req_i(periph_req),
    .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .spur_cnt_i(spur_cnt),
    .stat_o(stat), .mask_o(mask), .fld_o(fld)
  );

  pirq_level_decode #(
    .NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL)
  ) u_decode (
    .clk(clk), .rst(rst), .stat_i(stat), .mask_i(mask), .fld_i(fld),
    .hits_o(hits), .lvl_irq_o(lvl_irq)
  );

  pirq_select #(
    .NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .CNT_W(CNT_W), .SRC_W(SRC_W)
  ) u_select (
    .clk(clk), .rst(rst), .qry_valid(qry_valid), .qry_lvl(qry_lvl),
    .hits_i(hits), .rsp_valid(rsp_valid), .rsp_spurious(rsp_spurious),
    .rsp_src(rsp_src), .spur_cnt(spur_cnt)
  );

endmodule

// File: tb/pirq_level_router_bench.sv
`timescale 1ns/1ps
module pirq_level_router_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] periph_req = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:0]  lvl_irq;
  logic        qry_valid = 1'b0;
  logic [3:0]  qry_lvl = '0;
  logic        rsp_valid, rsp_spurious;
  logic [4:0]  rsp_src;

  int checks = 0, errors = 0;
  logic [31:0] m_stat = '0, m_mask = '0;
  logic [31:0] m_rte [4] = '{default: '0};
  int m_cnt = 0;

  always #4 clk = ~clk;

  pirq_level_router u_pirq_level_router (
    .clk(clk), .rst(rst), .periph_req(periph_req),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lvl_irq(lvl_irq),
    .qry_valid(qry_valid), .qry_lvl(qry_lvl), .rsp_valid(rsp_valid),
    .rsp_spurious(rsp_spurious), .rsp_src(rsp_src)
  );

  function automatic logic [3:0] fld(int n);
    return m_rte[n/8][(n%8)*4 +: 4];
  endfunction

  function automatic logic [6:0] exp_lvl();
    logic [6:0] r = '0;
    for (int n = 0; n < 32; n++)
      if (m_stat[n] && m_mask[n] && fld(n) < 4'd7) r[fld(n)] = 1'b1;
    return r;
  endfunction

  function automatic int exp_src(logic [3:0] lv);
    for (int n = 0; n < 32; n++)
      if (lv < 4'd7 && m_stat[n] && m_mask[n] && fld(n) == lv) return n;
    return -1;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(int a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
    if (a == 1) m_mask = d;
    if (a >= 2 && a <= 5) m_rte[a-2] = d;
  endtask

  task automatic rd_chk(int a, logic [31:0] exp, string req);
    bus_rd = 1'b1; bus_addr = 3'(a);
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, exp);
  endtask

  task automatic set_req(logic [31:0] v);
    periph_req = v;
    @(posedge clk); @(negedge clk);
    m_stat = v;
  endtask

  task automatic lvl_chk(string req);
    check(req, {25'd0, lvl_irq}, {25'd0, exp_lvl()});
  endtask

  task automatic qry(logic [3:0] lv, string req);
    int e;
    e = exp_src(lv);
    qry_valid = 1'b1; qry_lvl = lv;
    @(posedge clk); @(negedge clk);
    qry_valid = 1'b0;
    if (e < 0 && m_cnt < 255) m_cnt++;
    check(req, {rsp_valid, rsp_spurious, rsp_src},
          {1'b1, (e < 0), (e < 0) ? 5'd0 : 5'(e)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 lvl_irq", {25'd0, lvl_irq}, '0);
    check("R9 rsp_valid", {31'd0, rsp_valid}, '0);
    check("R9 rdata", bus_rdata, '0);
    rd_chk(1, '0, "R9 mask");
    rd_chk(2, '0, "R9 route");
    rd_chk(6, '0, "R9 counter");
    // R10 unused address
    rd_chk(7, '0, "R10 unused addr");
    // R2 mask zero hides requests
    set_req(32'hFFFF_FFFF);
    lvl_chk("R2 mask zero");
    // R1 status read, write ignored
    wr_reg(0, 32'h0);
    rd_chk(0, 32'hFFFF_FFFF, "R1 status write ignored");
    // R4 all at level 7 after mask enable
    wr_reg(1, 32'h0000_0100);
    lvl_chk("R4 level 7 default");
    qry(4'd0, "R6 default level src 8");
    // R3 field layout: source 13 -> level 12 (v=5), source 30 -> level 9 (v=2)
    wr_reg(3, 32'h0050_0000);
    wr_reg(5, 32'h0200_0000);
    wr_reg(1, 32'h4000_2000);
    set_req(32'h4000_2000);
    lvl_chk("R3 field placement");
    check("R3 level bits", {25'd0, lvl_irq}, 32'h24);
    rd_chk(3, 32'h0050_0000, "R3 route readback");
    // R5 out-of-range fields
    wr_reg(2, 32'hF700_0000);
    wr_reg(1, 32'hC000_0000 | 32'h0000_00C0);
    set_req(32'h0000_00C0);
    check("R5 no level", {25'd0, lvl_irq}, '0);
    qry(4'd0, "R5 never selected");
    // R6 lowest index wins
    wr_reg(2, 32'h0);
    wr_reg(1, 32'hFFFF_FFFF);
    set_req(32'h0000_0A48);
    qry(4'd0, "R6 lowest index");
    // R7 out-of-range level
    qry(4'd9, "R7 level above 6");
    qry(4'd7, "R7 level 7 offset");
    // R1 status follows input
    set_req(32'h1234_5678);
    rd_chk(0, 32'h1234_5678, "R1 status sample");
    // random mix
    for (int it = 0; it < 60; it++) begin
      for (int i = 0; i < 4; i++) wr_reg(2 + i, $urandom);
      wr_reg(1, $urandom | $urandom);
      set_req($urandom & $urandom);
      lvl_chk("R4 random");
      for (int lv = 0; lv < 8; lv++) qry(4'(lv), "R6 R7 random");
      if (it % 10 == 0) rd_chk(6, 32'(m_cnt), "R8 counter");
    end
    // R8 saturation
    wr_reg(1, 32'h0);
    for (int i = 0; i < 270; i++) qry(4'd3, "R8 spurious run");
    rd_chk(6, 32'd255, "R8 saturated");
    check("R8 model", 32'(m_cnt), 32'd255);
    repeat (3) @(negedge clk);
    rd_chk(6, 32'd255, "R8 idle stable");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule